// File: doc/BRIEF.md
# Polled Keyboard and Character Display Register Block

This block is a bus slave that gives a processor access to one keyboard input channel and one character display output channel through four word registers in a fixed address window at the top of the address space. Software polls a control word for each channel until its ready flag is set. It then moves one symbol through the matching data register.

On the keyboard side, the block takes one symbol from a valid/ready source and holds it until software reads it. While a symbol is waiting, the block holds off the source. On the display side, a write loads a symbol, and the block offers that symbol to a valid/ready sink until the sink takes it. The read data path is combinational. Register state changes at the clock edge that ends the access cycle.

Top module: `term_io_regs`

## Requirements
- R1: After reset, keyboard control reads 0, display control reads 1, `kb_ready` is 1 and `dp_valid` is 0.
- R2: The window base is 0xFFFF0000. Keyboard control is at +0, keyboard data at +4, display control at +8 and display data at +12. In each control word, bit 0 is the ready flag and bits 31:1 read as zero.
- R3: A keyboard symbol is latched at an edge where `kb_valid` and `kb_ready` are both high. From the next cycle, keyboard control reads 1 and `kb_ready` is 0.
- R4: A full-word read of keyboard data returns the latched symbol in bits 7:0 with zeros above it. The keyboard flag is 0 from the next cycle, and `kb_ready` returns to 1.
- R5: While the keyboard flag is 1, `kb_ready` stays 0, and source activity leaves the latched symbol unchanged.
- R6: When display control is 1, a full-word write to display data has the following effects. Bits 7:0 appear on `dp_data` with `dp_valid` high from the next cycle. Display control reads 0. Reading display data returns the whole written word. `dp_valid` and `dp_data` hold until `dp_ready` is seen.
- R7: At the edge where `dp_valid` and `dp_ready` are both high, the symbol is taken. From the next cycle `dp_valid` is 0 and display control reads 1.
- R8: A write to display data while display control is 0 is ignored. `dp_data` keeps the pending symbol, and no extra symbol reaches the sink.
- R9: An access outside the four registers reads as zero and changes nothing. This covers an address outside the window, an address whose low two bits are not zero, and +16 or above. Writes to the control registers and to keyboard data are also ignored.
- R10: An access with `bus_word` low is not decoded. It reads zero and has no side effect, so a partial read of keyboard data does not clear the keyboard flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Access strobe, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_word | input | 1 | 1 = full-word access |
| bus_addr | input | 32 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the access cycle |
| kb_valid | input | 1 | Keyboard source offers a symbol |
| kb_data | input | 8 | Keyboard symbol |
| kb_ready | output | 1 | Block can take a keyboard symbol |
| dp_valid | output | 1 | Display symbol pending |
| dp_data | output | 8 | Display symbol |
| dp_ready | input | 1 | Display sink takes the symbol |

## Verification
The keyboard path is tried in two ways. The first is a single symbol followed by a read. The second is a source that keeps offering new symbols while one is still waiting, which separates a correct hold-off from a design that overwrites the latched symbol. The display path is tried with a sink that stalls and then accepts, and with a sink that is always ready under back-to-back polled writes. A scoreboard compares every symbol the sink takes, so dropped symbols, duplicates and writes that should have been ignored all show up. Accesses outside the window, unaligned accesses and partial-width accesses are aimed at live registers, which separates a missing decode check from a correct one.

// File: rtl/term_io_pkg.sv
package term_io_pkg;
  typedef enum logic [1:0] {
    REG_KCTL = 2'd0,
    REG_KDAT = 2'd1,
    REG_DCTL = 2'd2,
    REG_DDAT = 2'd3
  } reg_idx_e;
endpackage

// File: rtl/term_io_decode.sv
module term_io_decode
  import term_io_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter logic [ADDR_W-1:0] BASE = 32'hFFFF0000
) (
  input  logic              sel,
  input  logic              word,
  input  logic [ADDR_W-1:0] addr,
  output logic              hit,
  output reg_idx_e          idx
);
  localparam int LOW_W = 4;

  function automatic logic in_window(input logic [ADDR_W-1:0] a);
    return (a[ADDR_W-1:LOW_W] == BASE[ADDR_W-1:LOW_W]) && (a[1:0] == 2'b00);
  endfunction

  assign hit = sel && word && in_window(addr);
  assign idx = reg_idx_e'(addr[3:2]);
endmodule

// File: rtl/term_io_kbd_port.sv
module term_io_kbd_port #(
  parameter int SYM_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             src_valid,
  input  logic [SYM_W-1:0] src_data,
  output logic             src_ready,
  input  logic             take,
  output logic             full,
  output logic [SYM_W-1:0] sym
);
  logic accept;

  assign src_ready = !full;
  assign accept    = src_valid && src_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      full <= 1'b0;
      sym  <= '0;
    end else if (accept) begin
      full <= 1'b1;
      sym  <= src_data;
    end else if (take) begin
      full <= 1'b0;
    end
  end

  // R3
  fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> full && (sym == $past(src_data)));
  // R4
  clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (full && take) |=> !full);
  // R5
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !take) |=> full && $stable(sym));
endmodule

// File: rtl/term_io_disp_port.sv
module term_io_disp_port #(
  parameter int DATA_W = 32,
  parameter int SYM_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              put,
  input  logic [DATA_W-1:0] put_word,
  output logic              idle,
  output logic [DATA_W-1:0] word,
  output logic              snk_valid,
  output logic [SYM_W-1:0]  snk_data,
  input  logic              snk_ready
);
  logic pending;
  logic load;

  assign idle      = !pending;
  assign load      = put && !pending;
  assign snk_valid = pending;
  assign snk_data  = word[SYM_W-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pending <= 1'b0;
      word    <= '0;
    end else if (load) begin
      pending <= 1'b1;
      word    <= put_word;
    end else if (pending && snk_ready) begin
      pending <= 1'b0;
    end
  end

  // R6
  stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (snk_valid && !snk_ready) |=> snk_valid && $stable(snk_data));
  // R7
  done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (snk_valid && snk_ready) |=> !snk_valid);
  // R8
  busy_put_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (put && snk_valid) |=> $stable(word));
endmodule

// File: rtl/term_io_regs.sv
module term_io_regs
  import term_io_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int SYM_W  = 8,
  parameter logic [ADDR_W-1:0] BASE = 32'hFFFF0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic              bus_word,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              kb_valid,
  input  logic [SYM_W-1:0]  kb_data,
  output logic              kb_ready,
  output logic              dp_valid,
  output logic [SYM_W-1:0]  dp_data,
  input  logic              dp_ready
);
  localparam int PAD_W = DATA_W - SYM_W;

  function automatic logic [DATA_W-1:0] flag_word(input logic f);
    return {{(DATA_W-1){1'b0}}, f};
  endfunction

  function automatic logic [DATA_W-1:0] sym_word(input logic [SYM_W-1:0] s);
    return {{PAD_W{1'b0}}, s};
  endfunction

  logic              hit;
  reg_idx_e          idx;
  logic              kbd_take;
  logic              disp_put;
  logic              kbd_full;
  logic [SYM_W-1:0]  kbd_sym;
  logic              disp_idle;
  logic [DATA_W-1:0] disp_word;

  term_io_decode #(.ADDR_W(ADDR_W), .BASE(BASE)) u_dec (
    .sel (bus_sel),
    .word(bus_word),
    .addr(bus_addr),
    .hit (hit),
    .idx (idx)
  );

  assign kbd_take = hit && !bus_we && (idx == REG_KDAT);
  assign disp_put = hit &&  bus_we && (idx == REG_DDAT);

  term_io_kbd_port #(.SYM_W(SYM_W)) u_kbd (
    .clk      (clk),
    .rst_n    (rst_n),
    .src_valid(kb_valid),
    .src_data (kb_data),
    .src_ready(kb_ready),
    .take     (kbd_take),
    .full     (kbd_full),
    .sym      (kbd_sym)
  );

  term_io_disp_port #(.DATA_W(DATA_W), .SYM_W(SYM_W)) u_disp (
    .clk      (clk),
    .rst_n    (rst_n),
    .put      (disp_put),
    .put_word (bus_wdata),
    .idle     (disp_idle),
    .word     (disp_word),
    .snk_valid(dp_valid),
    .snk_data (dp_data),
    .snk_ready(dp_ready)
  );

  always_comb begin
    bus_rdata = '0;
    if (hit && !bus_we) begin
      unique case (idx)
        REG_KCTL: bus_rdata = flag_word(kbd_full);
        REG_KDAT: bus_rdata = sym_word(kbd_sym);
        REG_DCTL: bus_rdata = flag_word(disp_idle);
        REG_DDAT: bus_rdata = disp_word;
      endcase
    end
  end

  // R9
  miss_rd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !hit) |-> (bus_rdata == '0));
  // R10
  part_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !bus_word && kbd_full && !kb_valid) |=> kbd_full);
endmodule

// File: tb/sim_term_io_regs.sv
module sim_term_io_regs;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0, bus_we = 1'b0, bus_word = 1'b1;
  logic [31:0] bus_addr = '0, bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        kb_valid = 1'b0;
  logic [7:0]  kb_data = '0;
  logic        kb_ready, dp_valid;
  logic [7:0]  dp_data;
  logic        dp_ready = 1'b0;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [7:0] exp_q[$];

  localparam logic [31:0] B = 32'hFFFF0000;

  always #4 clk = ~clk;

  term_io_regs u0 (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_word(bus_word), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .kb_valid(kb_valid), .kb_data(kb_data),
    .kb_ready(kb_ready), .dp_valid(dp_valid), .dp_data(dp_data),
    .dp_ready(dp_ready)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [31:0] a, input logic w, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b0; bus_word = w; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_sel = 1'b0; bus_word = 1'b1;
  endtask

  task automatic wr(input logic [31:0] a, input logic w, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b1; bus_word = w; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_we = 1'b0; bus_word = 1'b1;
  endtask

  task automatic kb_send(input logic [7:0] s);
    @(negedge clk);
    kb_valid = 1'b1; kb_data = s;
    @(negedge clk);
    kb_valid = 1'b0;
  endtask

  task automatic disp_send(input logic [31:0] w);
    logic [31:0] st;
    st = 0;
    while (st[0] !== 1'b1) rd(B + 8, 1'b1, st);
    exp_q.push_back(w[7:0]);
    wr(B + 12, 1'b1, w);
  endtask

  always begin
    @(negedge clk);
    #2;
    if (rst_n && dp_valid && dp_ready) begin
      if (exp_q.size() == 0) check("R7 unexpected symbol", {24'h0, dp_data}, 32'hFFFFFFFF);
      else check("R6 scoreboard symbol", {24'h0, dp_data}, {24'h0, exp_q.pop_front()});
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1 reset state
    check("R1 kb_ready", {31'h0, kb_ready}, 32'h1);
    check("R1 dp_valid", {31'h0, dp_valid}, 32'h0);
    rd(B + 0, 1'b1, d); check("R1 kbd ctrl", d, 32'h0);
    rd(B + 8, 1'b1, d); check("R1/R2 disp ctrl", d, 32'h1);

    // R3 single symbol
    kb_send(8'hA5);
    #1 check("R3 kb_ready low", {31'h0, kb_ready}, 32'h0);
    rd(B + 0, 1'b1, d); check("R3/R2 kbd ctrl", d, 32'h1);
    // R4 read clears
    rd(B + 4, 1'b1, d); check("R4 kbd data", d, 32'h000000A5);
    #1 check("R4 kb_ready back", {31'h0, kb_ready}, 32'h1);
    rd(B + 0, 1'b1, d); check("R4 kbd ctrl cleared", d, 32'h0);

    // R5 hold-off under persistent source
    kb_send(8'h3C);
    @(negedge clk);
    kb_valid = 1'b1; kb_data = 8'h77;
    repeat (4) begin
      @(negedge clk);
      #1 check("R5 kb_ready held", {31'h0, kb_ready}, 32'h0);
    end
    kb_valid = 1'b0;
    // R10 partial read does not clear
    rd(B + 4, 1'b0, d); check("R10 partial read zero", d, 32'h0);
    rd(B + 0, 1'b1, d); check("R10 flag kept", d, 32'h1);
    // R9 write to kbd data ignored
    wr(B + 4, 1'b1, 32'h000000EE);
    rd(B + 4, 1'b1, d); check("R5/R9 symbol kept", d, 32'h0000003C);

    // R6 display with stalled sink
    exp_q.push_back(8'h34);
    wr(B + 12, 1'b1, 32'hABCD1234);
    #1 check("R6 dp_valid", {31'h0, dp_valid}, 32'h1);
    check("R6 dp_data", {24'h0, dp_data}, 32'h34);
    rd(B + 8, 1'b1, d); check("R6 disp ctrl busy", d, 32'h0);
    rd(B + 12, 1'b1, d); check("R6 data readback", d, 32'hABCD1234);
    // R8 busy write ignored
    wr(B + 12, 1'b1, 32'h00000055);
    #1 check("R8 dp_data kept", {24'h0, dp_data}, 32'h34);
    // R7 accept
    @(negedge clk); dp_ready = 1'b1;
    @(negedge clk); dp_ready = 1'b0;
    #1 check("R7 dp_valid low", {31'h0, dp_valid}, 32'h0);
    rd(B + 8, 1'b1, d); check("R7 disp ctrl ready", d, 32'h1);

    // R9 out-of-window, unaligned, above map
    wr(B + 16, 1'b1, 32'h11);
    wr(32'h0000000C, 1'b1, 32'h22);
    wr(B + 13, 1'b1, 32'h33);
    #1 check("R9 writes ignored", {31'h0, dp_valid}, 32'h0);
    rd(32'h00000008, 1'b1, d); check("R9 outside read", d, 32'h0);
    rd(B + 10, 1'b1, d); check("R9 unaligned read", d, 32'h0);
    rd(B + 24, 1'b1, d); check("R9 above map read", d, 32'h0);
    // R10 partial write to display data
    wr(B + 12, 1'b0, 32'h44);
    #1 check("R10 partial write ignored", {31'h0, dp_valid}, 32'h0);
    // R9 control write ignored
    wr(B + 8, 1'b1, 32'h0);
    rd(B + 8, 1'b1, d); check("R9 ctrl write ignored", d, 32'h1);

    // R6/R7 back-to-back polled writes, sink always ready
    @(negedge clk); dp_ready = 1'b1;
    disp_send(32'h00000041);
    disp_send(32'h00000042);
    disp_send(32'hFFFFFF43);
    repeat (4) @(negedge clk);
    check("R7 scoreboard drained", exp_q.size(), 32'h0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule